// File: doc/BRIEF.md
# Switch Packet Destination Selector

This block decides where a received packet goes once its last byte has arrived. The destinations are the local ports of the switch device, the peer switch devices of a multi-chip system, and the management CPU. Each finished packet comes in as one descriptor. The descriptor carries the address lookup outcome, the packet-type flags and the end-of-packet status. The block turns it into one forwarding decision: a local port mask, a mask of peer devices that each get one buffer-request transfer, the first header word of that buffer request, and a CPU forward flag.

Descriptors enter on a valid/ready stream, and decisions leave on a second valid/ready stream. A decision is registered and appears one cycle after its descriptor is accepted. The block holds only one decision at a time. While a decision is waiting (`out_valid` high and `out_ready` low), `in_ready` is low and no new descriptor is taken. When the consumer takes a decision, a new descriptor can be accepted in that same cycle. The configuration pins are plain levels, and the device numbers are plain levels too. They must not change while a decision is being worked out or is waiting.

Three global control pins matter. One enables CPU forwarding. One sends every network multicast to the CPU alone. One lets unknown-destination packets reach the CPU. When the CPU sends a multicast back out, it supplies a port tag mask, and the receiving device uses only the ports in that mask.

Top module: `pkt_dest_sel`

## Requirements
- R1: `in_ready` is high exactly when no decision is waiting or `out_ready` is high. An accepted descriptor produces `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, every decision output holds its value.
- R2: A descriptor with `in_good` low gives a decision in which all masks, the header word and `out_cpu_fwd` are zero. This takes priority over every other rule.
- R3: A good unicast that is known and whose destination device equals `self_dev` gives a port mask with only bit `in_dst_port` set. The peer mask and header are zero.
- R4: A good unicast to any other device (not the CPU) sets only peer bit `in_dst_dev`. Header bit 21 is 0 and header bits [2:0] hold `in_dst_port`. The port mask is zero.
- R5: A good network multicast sets every local port bit and every peer bit except `self_dev`. The header is exactly bit 21 set. `out_cpu_fwd` equals `cfg_cpu_en`.
- R6: When both `cfg_mc_cpu_only` and `cfg_cpu_en` are high, a good network multicast gives only `out_cpu_fwd`=1, with zero masks. When `cfg_cpu_en` is low, `cfg_mc_cpu_only` has no effect.
- R7: A good multicast with `in_from_cpu` high gives a port mask equal to `in_eop_tags` (bits [29:22] of the end-of-packet message). The peer mask and header are zero, and there is no CPU forward.
- R8: With `cfg_cpu_en` low, `out_cpu_fwd` is always 0.
- R9: With `cfg_cpu_en` high, a good known unicast whose destination device equals `cpu_dev` gives only `out_cpu_fwd`=1. This check comes before the `self_dev` check.
- R10: A good BPDU or special management packet gives only `out_cpu_fwd` = `cfg_cpu_en`, with zero masks. It takes priority over the multicast, unknown and unicast rules.
- R11: A good unknown-destination packet that is not multicast gives zero masks, and `out_cpu_fwd` = `cfg_cpu_en` AND `cfg_unk_to_cpu`.
- R12: A good packet with `in_sniff` and `in_sniff_cpu` both high also sets `out_cpu_fwd` when `cfg_cpu_en` is high. Its masks are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cpu_en | input | 1 | CPU forwarding enable |
| cfg_mc_cpu_only | input | 1 | Send network multicast to the CPU only |
| cfg_unk_to_cpu | input | 1 | Send unknown-destination packets to the CPU |
| self_dev | input | DEV_W | This device's number |
| cpu_dev | input | DEV_W | Device number that stands for the CPU |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_good | input | 1 | Packet ended without error |
| in_mcast | input | 1 | Lookup result is multicast |
| in_unknown | input | 1 | Destination not found in the address table |
| in_from_cpu | input | 1 | Packet was sent by the CPU with a port tag |
| in_bpdu | input | 1 | Bridge protocol packet |
| in_mgmt | input | 1 | Special management packet |
| in_sniff | input | 1 | Packet is to be mirrored |
| in_sniff_cpu | input | 1 | The CPU is the mirror target |
| in_dst_dev | input | DEV_W | Destination device number from lookup |
| in_dst_port | input | PORT_W | Destination port from lookup |
| in_eop_tags | input | NUM_PORTS | CPU port tag mask (end-of-packet bits [29:22]) |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_port_mask | output | NUM_PORTS | Local ports to transmit on |
| out_peer_mask | output | NUM_DEVS | Peer devices that get one transfer each |
| out_peer_hdr | output | 32 | Buffer-request word 0 (bit 21 marks multicast) |
| out_cpu_fwd | output | 1 | Forward to CPU memory |

## Verification
The properties assume three things about the inputs. The configuration pins stay fixed while a descriptor is being decided or its decision is waiting. `self_dev` and `cpu_dev` stay fixed in the same way. The consumer only pulls `out_ready` to take a decision. Under these assumptions, a checked decision can be compared with the current levels of the control pins. The stimulus changes the configuration and the device numbers only between transactions, after the previous decision has been taken and `out_valid` has dropped.

The stimulus sweeps every mix of the eight packet flags, every destination device, every configuration triple and two device-number layouts. Some decisions are stalled before they are taken.

// File: rtl/pds_pkg.sv
package pds_pkg;

  localparam int MC_FLAG_BIT = 21;
  localparam int HDR_W       = 32;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_CPU    = 3'd1,
    CLS_TAGGED = 3'd2,
    CLS_FLOOD  = 3'd3,
    CLS_LOCAL  = 3'd4,
    CLS_REMOTE = 3'd5
  } pds_class_e;

endpackage

// File: rtl/pds_classify.sv
module pds_classify
  import pds_pkg::*;
#(
  parameter int DEV_W = 2
) (
  input  logic             good,
  input  logic             mcast,
  input  logic             unknown,
  input  logic             from_cpu,
  input  logic             bpdu,
  input  logic             mgmt,
  input  logic             sniff,
  input  logic             sniff_cpu,
  input  logic [DEV_W-1:0] dst_dev,
  input  logic [DEV_W-1:0] self_dev,
  input  logic [DEV_W-1:0] cpu_dev,
  input  logic             cpu_en,
  input  logic             mc_cpu_only,
  input  logic             unk_to_cpu,
  output pds_class_e       cls,
  output logic             cpu_tap
);

  logic to_cpu_dev;
  logic to_self;

  assign to_cpu_dev = cpu_en && (dst_dev == cpu_dev);
  assign to_self    = (dst_dev == self_dev);

  // priority: error, control packets, tagged, multicast, unknown, unicast
  always_comb begin
    cls = CLS_NONE;
    if (!good) begin
      cls = CLS_NONE;
    end else if (bpdu || mgmt) begin
      cls = cpu_en ? CLS_CPU : CLS_NONE;
    end else if (mcast && from_cpu) begin
      cls = CLS_TAGGED;
    end else if (mcast) begin
      cls = (cpu_en && mc_cpu_only) ? CLS_CPU : CLS_FLOOD;
    end else if (unknown) begin
      cls = (cpu_en && unk_to_cpu) ? CLS_CPU : CLS_NONE;
    end else if (to_cpu_dev) begin
      cls = CLS_CPU;
    end else if (to_self) begin
      cls = CLS_LOCAL;
    end else begin
      cls = CLS_REMOTE;
    end
  end

  assign cpu_tap = good && cpu_en && sniff && sniff_cpu;

endmodule

// File: rtl/pds_mask_gen.sv
module pds_mask_gen
  import pds_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_DEVS  = 4,
  parameter int DEV_W     = 2,
  parameter int PORT_W    = 3
) (
  input  pds_class_e           cls,
  input  logic                 cpu_tap,
  input  logic                 cpu_en,
  input  logic [DEV_W-1:0]     dst_dev,
  input  logic [PORT_W-1:0]    dst_port,
  input  logic [DEV_W-1:0]     self_dev,
  input  logic [NUM_PORTS-1:0] tags,
  output logic [NUM_PORTS-1:0] port_mask,
  output logic [NUM_DEVS-1:0]  peer_mask,
  output logic [HDR_W-1:0]     peer_hdr,
  output logic                 cpu_fwd
);

  logic [NUM_DEVS-1:0]  peers_all;
  logic [NUM_DEVS-1:0]  peer_one;
  logic [NUM_PORTS-1:0] port_one;

  for (genvar g = 0; g < NUM_DEVS; g++) begin : g_peer
    assign peers_all[g] = (self_dev != DEV_W'(g));
    assign peer_one[g]  = (dst_dev  == DEV_W'(g));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_one[p] = (dst_port == PORT_W'(p));
  end

  always_comb begin
    port_mask = '0;
    peer_mask = '0;
    peer_hdr  = '0;
    cpu_fwd   = 1'b0;
    unique case (cls)
      CLS_CPU:    cpu_fwd = 1'b1;
      CLS_TAGGED: port_mask = tags;
      CLS_FLOOD: begin
        port_mask              = '1;
        peer_mask              = peers_all;
        peer_hdr[MC_FLAG_BIT]  = 1'b1;
        cpu_fwd                = cpu_en;
      end
      CLS_LOCAL:  port_mask = port_one;
      CLS_REMOTE: begin
        peer_mask               = peer_one;
        peer_hdr[PORT_W-1:0]    = dst_port;
      end
      default: ;
    endcase
    cpu_fwd = cpu_fwd | cpu_tap;
  end

endmodule

// File: rtl/pds_out_stage.sv
module pds_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  logic         held;
  logic [W-1:0] data_q;

  assign s_ready = !held || m_ready;
  assign m_valid = held;
  assign m_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      data_q <= '0;
    end else if (s_valid && s_ready) begin
      held   <= 1'b1;
      data_q <= s_data;
    end else if (m_ready) begin
      held   <= 1'b0;
    end
  end

endmodule

// File: rtl/pkt_dest_sel.sv
module pkt_dest_sel
  import pds_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_DEVS  = 4,
  parameter int DEV_W     = (NUM_DEVS > 1) ? $clog2(NUM_DEVS) : 1,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_cpu_en,
  input  logic                 cfg_mc_cpu_only,
  input  logic                 cfg_unk_to_cpu,
  input  logic [DEV_W-1:0]     self_dev,
  input  logic [DEV_W-1:0]     cpu_dev,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_good,
  input  logic                 in_mcast,
  input  logic                 in_unknown,
  input  logic                 in_from_cpu,
  input  logic                 in_bpdu,
  input  logic                 in_mgmt,
  input  logic                 in_sniff,
  input  logic                 in_sniff_cpu,
  input  logic [DEV_W-1:0]     in_dst_dev,
  input  logic [PORT_W-1:0]    in_dst_port,
  input  logic [NUM_PORTS-1:0] in_eop_tags,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PORTS-1:0] out_port_mask,
  output logic [NUM_DEVS-1:0]  out_peer_mask,
  output logic [HDR_W-1:0]     out_peer_hdr,
  output logic                 out_cpu_fwd
);

  localparam int DEC_W = NUM_PORTS + NUM_DEVS + HDR_W + 1;

  pds_class_e           cls;
  logic                 cpu_tap;
  logic [NUM_PORTS-1:0] nx_ports;
  logic [NUM_DEVS-1:0]  nx_peers;
  logic [HDR_W-1:0]     nx_hdr;
  logic                 nx_cpu;
  logic [DEC_W-1:0]     nx_dec;
  logic [DEC_W-1:0]     q_dec;

  pds_classify #(.DEV_W(DEV_W)) u_cls (
    .good        (in_good),
    .mcast       (in_mcast),
    .unknown     (in_unknown),
    .from_cpu    (in_from_cpu),
    .bpdu        (in_bpdu),
    .mgmt        (in_mgmt),
    .sniff       (in_sniff),
    .sniff_cpu   (in_sniff_cpu),
    .dst_dev     (in_dst_dev),
    .self_dev    (self_dev),
    .cpu_dev     (cpu_dev),
    .cpu_en      (cfg_cpu_en),
    .mc_cpu_only (cfg_mc_cpu_only),
    .unk_to_cpu  (cfg_unk_to_cpu),
    .cls         (cls),
    .cpu_tap     (cpu_tap)
  );

  pds_mask_gen #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_DEVS  (NUM_DEVS),
    .DEV_W     (DEV_W),
    .PORT_W    (PORT_W)
  ) u_mask (
    .cls       (cls),
    .cpu_tap   (cpu_tap),
    .cpu_en    (cfg_cpu_en),
    .dst_dev   (in_dst_dev),
    .dst_port  (in_dst_port),
    .self_dev  (self_dev),
    .tags      (in_eop_tags),
    .port_mask (nx_ports),
    .peer_mask (nx_peers),
    .peer_hdr  (nx_hdr),
    .cpu_fwd   (nx_cpu)
  );

  assign nx_dec = {nx_ports, nx_peers, nx_hdr, nx_cpu};

  pds_out_stage #(.W(DEC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (nx_dec),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (q_dec)
  );

  assign {out_port_mask, out_peer_mask, out_peer_hdr, out_cpu_fwd} = q_dec;

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_DEVS  = 4,
  parameter int DEV_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_cpu_en,
  input logic [DEV_W-1:0]     self_dev,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NUM_PORTS-1:0] out_port_mask,
  input logic [NUM_DEVS-1:0]  out_peer_mask,
  input logic [31:0]          out_peer_hdr,
  input logic                 out_cpu_fwd
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port_mask)
      && $stable(out_peer_mask) && $stable(out_peer_hdr) && $stable(out_cpu_fwd));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_no_self_peer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_peer_mask[self_dev]);

  assert_cpu_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_cpu_en |-> !out_cpu_fwd);

  assert_uni_peer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_peer_mask != '0) && !out_peer_hdr[21]
      |-> $countones(out_peer_mask) == 1);

  assert_mc_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($countones(out_peer_mask) > 1) |-> out_peer_hdr[21]);

endmodule

bind pkt_dest_sel pds_checker #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_DEVS  (NUM_DEVS),
  .DEV_W     (DEV_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_cpu_en    (cfg_cpu_en),
  .self_dev      (self_dev),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_port_mask (out_port_mask),
  .out_peer_mask (out_peer_mask),
  .out_peer_hdr  (out_peer_hdr),
  .out_cpu_fwd   (out_cpu_fwd)
);

// File: tb/sim_pkt_dest_sel.sv
module sim_pkt_dest_sel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cfg_cpu_en = 0, cfg_mc_cpu_only = 0, cfg_unk_to_cpu = 0;
  logic [1:0] self_dev = 2'd1, cpu_dev = 2'd3;
  logic       in_valid = 0;
  logic       in_ready;
  logic       in_good = 0, in_mcast = 0, in_unknown = 0, in_from_cpu = 0;
  logic       in_bpdu = 0, in_mgmt = 0, in_sniff = 0, in_sniff_cpu = 0;
  logic [1:0] in_dst_dev = 0;
  logic [2:0] in_dst_port = 0;
  logic [7:0] in_eop_tags = 0;
  logic       out_valid;
  logic       out_ready = 0;
  logic [7:0] out_port_mask;
  logic [3:0] out_peer_mask;
  logic [31:0] out_peer_hdr;
  logic       out_cpu_fwd;

  pkt_dest_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpu_en(cfg_cpu_en), .cfg_mc_cpu_only(cfg_mc_cpu_only), .cfg_unk_to_cpu(cfg_unk_to_cpu),
    .self_dev(self_dev), .cpu_dev(cpu_dev),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_good(in_good), .in_mcast(in_mcast), .in_unknown(in_unknown), .in_from_cpu(in_from_cpu),
    .in_bpdu(in_bpdu), .in_mgmt(in_mgmt), .in_sniff(in_sniff), .in_sniff_cpu(in_sniff_cpu),
    .in_dst_dev(in_dst_dev), .in_dst_port(in_dst_port), .in_eop_tags(in_eop_tags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_port_mask(out_port_mask), .out_peer_mask(out_peer_mask),
    .out_peer_hdr(out_peer_hdr), .out_cpu_fwd(out_cpu_fwd)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected decision, from the requirements
  logic [7:0]  e_ports;
  logic [3:0]  e_peers;
  logic [31:0] e_hdr;
  logic        e_cpu;
  string       e_req;
  string       c_req;

  task automatic model();
    e_ports = 0; e_peers = 0; e_hdr = 0; e_cpu = 0;
    if (!in_good) begin
      e_req = "R2";
    end else if (in_bpdu || in_mgmt) begin
      e_req = "R10"; e_cpu = cfg_cpu_en;
    end else if (in_mcast && in_from_cpu) begin
      e_req = "R7"; e_ports = in_eop_tags;
    end else if (in_mcast) begin
      if (cfg_cpu_en && cfg_mc_cpu_only) begin
        e_req = "R6"; e_cpu = 1;
      end else begin
        e_req = "R5"; e_ports = 8'hFF;
        e_peers = 4'hF & ~(4'd1 << self_dev);
        e_hdr = 32'd1 << 21; e_cpu = cfg_cpu_en;
      end
    end else if (in_unknown) begin
      e_req = "R11"; e_cpu = cfg_cpu_en && cfg_unk_to_cpu;
    end else if (cfg_cpu_en && in_dst_dev == cpu_dev) begin
      e_req = "R9"; e_cpu = 1;
    end else if (in_dst_dev == self_dev) begin
      e_req = "R3"; e_ports = 8'd1 << in_dst_port;
    end else begin
      e_req = "R4"; e_peers = 4'd1 << in_dst_dev; e_hdr = {29'd0, in_dst_port};
    end
    c_req = e_req;
    if (in_good && cfg_cpu_en && in_sniff && in_sniff_cpu) begin
      e_cpu = 1; c_req = "R12";
    end
    if (!cfg_cpu_en) c_req = "R8";
  endtask

  task automatic cmp_all(input string tag);
    chk(out_port_mask == e_ports, e_req, {tag, " port_mask"}, 64'(out_port_mask), 64'(e_ports));
    chk(out_peer_mask == e_peers, e_req, {tag, " peer_mask"}, 64'(out_peer_mask), 64'(e_peers));
    chk(out_peer_hdr == e_hdr,    e_req, {tag, " peer_hdr"},  64'(out_peer_hdr),  64'(e_hdr));
    chk(out_cpu_fwd == e_cpu,     c_req, {tag, " cpu_fwd"},   64'(out_cpu_fwd),   64'(e_cpu));
  endtask

  int tx = 0;

  task automatic run_tx(input logic [7:0] flags, input logic [1:0] dev, input logic [2:0] port,
                        input logic [7:0] tags);
    @(negedge clk);
    {in_good, in_mcast, in_unknown, in_from_cpu, in_bpdu, in_mgmt, in_sniff, in_sniff_cpu} = flags;
    in_dst_dev = dev; in_dst_port = port; in_eop_tags = tags;
    in_valid = 1;
    model();
    chk(in_ready == 1'b1, "R1", "in_ready idle", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 0;
    in_good = 0; in_mcast = 0; in_eop_tags = ~tags; in_dst_port = ~port;
    chk(out_valid == 1'b1, "R1", "out_valid after accept", 64'(out_valid), 64'd1);
    cmp_all("decision");
    if (tx % 7 == 0) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        chk(out_valid == 1'b1, "R1", "held valid", 64'(out_valid), 64'd1);
        chk(in_ready == 1'b0, "R1", "in_ready stalled", 64'(in_ready), 64'd0);
        cmp_all("stalled");
      end
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 1'b0, "R1", "out_valid after take", 64'(out_valid), 64'd0);
    tx++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "post-reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", "post-reset in_ready", 64'(in_ready), 64'd1);
    for (int lay = 0; lay < 2; lay++) begin
      self_dev = (lay == 0) ? 2'd1 : 2'd2;
      cpu_dev  = (lay == 0) ? 2'd3 : 2'd0;
      for (int cfg = 0; cfg < 8; cfg++) begin
        {cfg_cpu_en, cfg_mc_cpu_only, cfg_unk_to_cpu} = 3'(cfg);
        for (int f = 0; f < 256; f++) begin
          for (int d = 0; d < 4; d++) begin
            run_tx(8'(f), 2'(d), 3'(f + d + cfg), 8'(f) ^ 8'h5A ^ 8'(cfg));
          end
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", tx, 16384);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule